// File: doc/BRIEF.md
# Indexed-Colour Frame Store with Raster Read-Out

This block sits between a pixel producer and a display raster that run on unrelated clocks. The producer side writes one 6-bit colour index per pixel, addressed by column and source line. Only the central band of source lines is kept. The same number of lines is trimmed from the top and from the bottom, and writes aimed at the trimmed lines leave the store unchanged. The depth of the store is therefore the kept line count times the line width, and each entry holds an index, not a colour.

The display side receives a data-enable flag and the current horizontal and vertical position from an external raster timing generator. It works out which stored pixel falls under that position and reads it in one display clock. A second display clock maps the index through a 64-entry colour table to 15-bit RGB, with 5 bits for each channel. The picture can be scaled up by two in both directions and is centred in the active area. Outside that window, and whenever data-enable is low, the output is black. The colour table is filled from computed constants during reset and cannot be changed afterwards.

In a full-size build the source picture is 256 pixels by 240 lines with 8 lines trimmed at each end. That gives a 512 by 448 window, centred in a 640 by 480 raster. The defaults are a scaled-down geometry that keeps the same structure.

Top module: `pfb_scanout`

## Requirements
- R1: A write with `wr_en` high, line `wr_y` in [TRIM, SRC_LINES-TRIM) and column `wr_x` stores `wr_idx` at stored row `wr_y-TRIM`, column `wr_x`. A later write to the same location replaces the earlier one.
- R2: A write whose line is below TRIM, or at or above SRC_LINES-TRIM, changes no stored entry.
- R3: With DOUBLE=1 the window is 2*SRC_W by 2*(SRC_LINES-2*TRIM) positions. It starts at HOFF=(H_ACT-2*SRC_W)/2 and VOFF=(V_ACT-2*(SRC_LINES-2*TRIM))/2. Position (h,v) inside it shows stored row (v-VOFF)/2, column (h-HOFF)/2, with integer division.
- R4: Stored index i is shown as `rgb` bits [14:10] = {i[1:0],i[1:0],i[1]}, bits [9:5] = {i[3:2],i[3:2],i[3]} and bits [4:0] = {i[5:4],i[5:4],i[5]}.
- R5: A position outside the window, with data-enable high, produces `rgb` equal to zero.
- R6: Data-enable low produces `rgb` equal to zero, whatever the position.
- R7: The `rgb` value for inputs sampled at one `rd_clk` rising edge appears after the second following rising edge. The enable and window qualifiers are delayed to match.
- R8: While `rd_rst_n` is low, `rgb` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer pixel clock |
| wr_en | input | 1 | Write strobe for one pixel |
| wr_x | input | XW (5) | Source column |
| wr_y | input | YW (6) | Source line, including the trimmed lines |
| wr_idx | input | 6 | Colour index to store |
| rd_clk | input | 1 | Display clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset, display domain |
| de | input | 1 | Raster data-enable |
| hpos | input | HW (8) | Raster column |
| vpos | input | VW (8) | Raster line |
| rgb | output | 15 | Pixel colour, R in [14:10], G in [9:5], B in [4:0] |

## Verification
The bench builds the block with its defaults: a 32-column, 48-line source with 8 lines trimmed at each end, doubled into a 64 by 64 window inside an 80 by 72 active area. Because the kept band is 32 lines, a power of two, a write to a trimmed line would wrap onto a real stored row if its line gate were missing. That makes R2 visible when the whole frame is read back. The small geometry lets every raster position, including blanking columns and lines, be swept in one pass. A fill pattern that uses all 64 indices covers the whole colour table.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
   localparam int IDX_W = 6;
   localparam int PAL_N = 1 << IDX_W;
   localparam int RGB_W = 15;

   typedef logic [IDX_W-1:0] cidx_t;
   typedef logic [RGB_W-1:0] rgb_t;

   // Spread each 2-bit field of the index across a 5-bit channel.
   function automatic rgb_t idx_to_rgb(input cidx_t i);
      rgb_t c;
      c[14:10] = {i[1:0], i[1:0], i[1]};
      c[9:5]   = {i[3:2], i[3:2], i[3]};
      c[4:0]   = {i[5:4], i[5:4], i[5]};
      return c;
   endfunction
endpackage

// File: rtl/pfb_store.sv
module pfb_store #(
   parameter int SRC_W     = 32,
   parameter int SRC_LINES = 48,
   parameter int TRIM      = 8,
   localparam int XW       = $clog2(SRC_W),
   localparam int YW       = $clog2(SRC_LINES),
   localparam int KEEP_H   = SRC_LINES - 2*TRIM,
   localparam int RW       = $clog2(KEEP_H),
   localparam int DEPTH    = SRC_W * KEEP_H
) (
   input  logic                 wr_clk,
   input  logic                 wr_en,
   input  logic [XW-1:0]        wr_x,
   input  logic [YW-1:0]        wr_y,
   input  pfb_pkg::cidx_t       wr_idx,
   input  logic                 rd_clk,
   input  logic [RW+XW-1:0]     rd_addr,
   output pfb_pkg::cidx_t       rd_idx
);
   pfb_pkg::cidx_t mem [DEPTH];

   logic          line_kept;
   logic [RW-1:0] wr_row;

   assign line_kept = (wr_y >= YW'(TRIM)) && (wr_y < YW'(SRC_LINES - TRIM));
   assign wr_row    = RW'(wr_y - YW'(TRIM));

   always_ff @(posedge wr_clk) begin
      if (wr_en && line_kept)
         mem[{wr_row, wr_x}] <= wr_idx;
   end

   always_ff @(posedge rd_clk) begin
      rd_idx <= mem[rd_addr];
   end
endmodule

// File: rtl/pfb_window.sv
module pfb_window #(
   parameter int SRC_W  = 32,
   parameter int KEEP_H = 32,
   parameter int H_ACT  = 80,
   parameter int V_ACT  = 72,
   parameter int HW     = 8,
   parameter int VW     = 8,
   parameter bit DOUBLE = 1'b1,
   localparam int SH    = DOUBLE ? 1 : 0,
   localparam int WIN_W = SRC_W << SH,
   localparam int WIN_H = KEEP_H << SH,
   localparam int HOFF  = (H_ACT - WIN_W) / 2,
   localparam int VOFF  = (V_ACT - WIN_H) / 2,
   localparam int XW    = $clog2(SRC_W),
   localparam int RW    = $clog2(KEEP_H)
) (
   input  logic              de,
   input  logic [HW-1:0]     hpos,
   input  logic [VW-1:0]     vpos,
   output logic              in_win,
   output logic [RW+XW-1:0]  rd_addr
);
   logic [HW-1:0] hrel;
   logic [VW-1:0] vrel;
   logic [XW-1:0] col;
   logic [RW-1:0] row;

   assign hrel   = hpos - HW'(HOFF);
   assign vrel   = vpos - VW'(VOFF);
   assign in_win = de
                   && (hpos >= HW'(HOFF)) && (hpos < HW'(HOFF + WIN_W))
                   && (vpos >= VW'(VOFF)) && (vpos < VW'(VOFF + WIN_H));

   generate
      if (DOUBLE) begin : g_double
         assign col = XW'(hrel >> 1);
         assign row = RW'(vrel >> 1);
      end else begin : g_native
         assign col = XW'(hrel);
         assign row = RW'(vrel);
      end
   endgenerate

   assign rd_addr = {row, col};
endmodule

// File: rtl/pfb_palette.sv
module pfb_palette (
   input  logic            rd_clk,
   input  logic            rd_rst_n,
   input  logic            vis,
   input  pfb_pkg::cidx_t  idx,
   output pfb_pkg::rgb_t   rgb
);
   import pfb_pkg::*;

   rgb_t tbl [PAL_N];

   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) begin
         for (int k = 0; k < PAL_N; k++)
            tbl[k] <= idx_to_rgb(cidx_t'(k));
         rgb <= '0;
      end else begin
         rgb <= vis ? tbl[idx] : '0;
      end
   end
endmodule

// File: rtl/pfb_scanout.sv
module pfb_scanout #(
   parameter int SRC_W     = 32,
   parameter int SRC_LINES = 48,
   parameter int TRIM      = 8,
   parameter int H_ACT     = 80,
   parameter int V_ACT     = 72,
   parameter int HW        = 8,
   parameter int VW        = 8,
   parameter bit DOUBLE    = 1'b1,
   localparam int XW       = $clog2(SRC_W),
   localparam int YW       = $clog2(SRC_LINES),
   localparam int KEEP_H   = SRC_LINES - 2*TRIM,
   localparam int RW       = $clog2(KEEP_H)
) (
   input  logic          wr_clk,
   input  logic          wr_en,
   input  logic [XW-1:0] wr_x,
   input  logic [YW-1:0] wr_y,
   input  logic [5:0]    wr_idx,
   input  logic          rd_clk,
   input  logic          rd_rst_n,
   input  logic          de,
   input  logic [HW-1:0] hpos,
   input  logic [VW-1:0] vpos,
   output logic [14:0]   rgb
);
   localparam int SCALE = DOUBLE ? 2 : 1;

   generate
      if ((1 << XW) != SRC_W)
         $error("SRC_W must be a power of two");
      if (KEEP_H < 1)
         $error("TRIM removes every source line");
      if (SRC_W * SCALE > H_ACT || KEEP_H * SCALE > V_ACT)
         $error("window does not fit the active area");
      if ((1 << HW) < H_ACT || (1 << VW) < V_ACT)
         $error("position width too narrow");
   endgenerate

   logic                 in_win;
   logic                 vis_q;
   logic [RW+XW-1:0]     rd_addr;
   pfb_pkg::cidx_t       rd_idx;

   pfb_window #(
      .SRC_W(SRC_W), .KEEP_H(KEEP_H), .H_ACT(H_ACT), .V_ACT(V_ACT),
      .HW(HW), .VW(VW), .DOUBLE(DOUBLE)
   ) u_win (
      .de(de), .hpos(hpos), .vpos(vpos), .in_win(in_win), .rd_addr(rd_addr)
   );

   pfb_store #(
      .SRC_W(SRC_W), .SRC_LINES(SRC_LINES), .TRIM(TRIM)
   ) u_store (
      .wr_clk(wr_clk), .wr_en(wr_en), .wr_x(wr_x), .wr_y(wr_y),
      .wr_idx(wr_idx), .rd_clk(rd_clk), .rd_addr(rd_addr), .rd_idx(rd_idx)
   );

   // Qualifier travels alongside the RAM read stage.
   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) vis_q <= 1'b0;
      else           vis_q <= in_win;
   end

   pfb_palette u_pal (
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .vis(vis_q), .idx(rd_idx), .rgb(rgb)
   );
endmodule

// File: rtl/pfb_checker.sv
module pfb_checker #(
   parameter int SRC_W  = 32,
   parameter int KEEP_H = 32,
   parameter int H_ACT  = 80,
   parameter int V_ACT  = 72,
   parameter int HW     = 8,
   parameter int VW     = 8,
   parameter bit DOUBLE = 1'b1
) (
   input logic          rd_clk,
   input logic          rd_rst_n,
   input logic          de,
   input logic [HW-1:0] hpos,
   input logic [VW-1:0] vpos,
   input logic [14:0]   rgb
);
   localparam int WW = DOUBLE ? 2*SRC_W : SRC_W;
   localparam int WH = DOUBLE ? 2*KEEP_H : KEEP_H;
   localparam int HO = (H_ACT - WW) / 2;
   localparam int VO = (V_ACT - WH) / 2;

   logic [1:0] since_rst;
   logic       outside;

   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n)              since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   assign outside = (int'(hpos) < HO) || (int'(hpos) >= HO + WW) ||
                    (int'(vpos) < VO) || (int'(vpos) >= VO + WH);

   p_blank_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (since_rst >= 2'd2 && !$past(de, 2)) |-> (rgb == '0));

   p_outside_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (since_rst >= 2'd2 && $past(outside, 2)) |-> (rgb == '0));

   p_chan_form_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rgb[14:13] == rgb[12:11]) && (rgb[10] == rgb[14]) &&
      (rgb[9:8] == rgb[7:6]) && (rgb[5] == rgb[9]) &&
      (rgb[4:3] == rgb[2:1]) && (rgb[0] == rgb[4]));

   p_reset_dark_r8: assert property (@(posedge rd_clk)
      (!rd_rst_n) |-> (rgb == '0));
endmodule

bind pfb_scanout pfb_checker #(
   .SRC_W(SRC_W), .KEEP_H(KEEP_H), .H_ACT(H_ACT), .V_ACT(V_ACT),
   .HW(HW), .VW(VW), .DOUBLE(DOUBLE)
) u_chk (
   .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .de(de),
   .hpos(hpos), .vpos(vpos), .rgb(rgb)
);

// File: tb/sim_pfb_scanout.sv
`timescale 1ns/100ps
module sim_pfb_scanout;
   localparam int SW = 32, SL = 48, TR = 8, KH = SL - 2*TR;
   localparam int HA = 80, VA = 72, HO = 8, VO = 4;

   logic       wr_clk = 0, rd_clk = 0;
   logic       wr_en = 0;
   logic [4:0] wr_x = '0;
   logic [5:0] wr_y = '0;
   logic [5:0] wr_idx = '0;
   logic       rd_rst_n = 0;
   logic       de = 0;
   logic [7:0] hpos = '0, vpos = '0;
   logic [14:0] rgb;

   int img [KH][SW];
   int exp_q[$];
   int tag_q[$];
   int checks = 0, fails = 0;
   bit done = 0;

   always #2.5 rd_clk = ~rd_clk;
   always #3.5 wr_clk = ~wr_clk;

   pfb_scanout u0 (
      .wr_clk(wr_clk), .wr_en(wr_en), .wr_x(wr_x), .wr_y(wr_y), .wr_idx(wr_idx),
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .de(de), .hpos(hpos), .vpos(vpos),
      .rgb(rgb)
   );

   function automatic int chan(int two);
      return two * 8 + two * 2 + two / 2;
   endfunction

   function automatic int colour(int i);
      return chan(i % 4) * 1024 + chan((i / 4) % 4) * 32 + chan((i / 16) % 4);
   endfunction

   // tag: 0 = R6 blank, 1 = R5 outside, 2 = window pixel
   function automatic int classify(bit d, int h, int v);
      if (!d) return 0;
      if (h < HO || h >= HO + 2*SW || v < VO || v >= VO + 2*KH) return 1;
      return 2;
   endfunction

   task automatic check(int got, int want, int tag);
      checks++;
      if (got != want) begin
         fails++;
         case (tag)
            0: $display("FAIL R6 blanking: rgb=%h expected %h", got, want);
            1: $display("FAIL R5 outside window: rgb=%h expected %h", got, want);
            2: $display("FAIL R1 R2 R3 R4 R7 pixel: rgb=%h expected %h", got, want);
            default: $display("FAIL R8 reset: rgb=%h expected %h", got, want);
         endcase
      end
   endtask

   task automatic wr(int x, int y, int idx);
      @(negedge wr_clk);
      wr_en = 1; wr_x = 5'(x); wr_y = 6'(y); wr_idx = 6'(idx);
      @(posedge wr_clk);
      #1 wr_en = 0;
      if (y >= TR && y < SL - TR) img[y - TR][x] = idx;   // R1; else R2 leaves model alone
   endtask

   // One display cycle: compare the result of inputs given two edges ago (R7).
   task automatic rd(bit d, int h, int v);
      int t;
      @(negedge rd_clk);
      if (exp_q.size() == 2) check(int'(rgb), exp_q.pop_front(), tag_q.pop_front());
      de = d; hpos = 8'(h); vpos = 8'(v);
      t = classify(d, h, v);
      tag_q.push_back(t);
      exp_q.push_back(t == 2 ? colour(img[(v - VO) / 2][(h - HO) / 2]) : 0);
   endtask

   initial begin
      repeat (100000) @(posedge rd_clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      // R8: window pixel requested while in reset must stay dark.
      de = 1; hpos = 8'(HO + 4); vpos = 8'(VO + 4);
      for (int i = 0; i < 4; i++) begin
         @(negedge rd_clk);
         check(int'(rgb), 0, 3);
      end
      // Fill every kept pixel, covering all 64 indices (R1, R4).
      for (int y = TR; y < SL - TR; y++)
         for (int x = 0; x < SW; x++)
            wr(x, y, (x * 3 + y * 7 + x / 4) % 64);
      // Overwrite a few locations (R1 latest wins).
      wr(0, TR, 63); wr(31, SL - TR - 1, 42); wr(5, 20, 17);
      // Dropped lines: top and bottom bands must not land anywhere (R2).
      for (int y = 0; y < TR; y++)
         for (int x = 0; x < SW; x += 3) wr(x, y, 9);
      for (int y = SL - TR; y < SL; y++)
         for (int x = 1; x < SW; x += 3) wr(x, y, 54);
      @(negedge rd_clk);
      de = 0;
      rd_rst_n = 1;
      // Full raster sweep including blanking (R3, R5, R6).
      for (int v = 0; v < VA + 4; v++)
         for (int h = 0; h < HA + 20; h++)
            rd(h < HA && v < VA, h, v);
      // Scattered positions with enable toggling.
      for (int i = 0; i < 3000; i++)
         rd(($urandom % 4) != 0, $urandom % (HA + 10), $urandom % (VA + 6));
      // Enable low inside the window (R6).
      for (int i = 0; i < 64; i++)
         rd(1'b0, HO + i, VO + i / 2);
      rd(1'b0, 0, 0); rd(1'b0, 0, 0); rd(1'b0, 0, 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule